// File: doc/BRIEF.md
# Network-Time Counter Clock Supervisor

This block keeps a free-running counter whose increment source is chosen by software. There are three sources. The first is an internal tick made by a programmable prescaler from the system clock. The second is an external network macrotick pulse. The third is an external network cycle-start pulse. The counter can therefore follow a communication network's time base, so that operating-system ticks stay aligned with the bus schedule.

When an external source drives the counter, a supervision window guards it. The window is measured in internal prescaled ticks and restarts each time the selected pulse arrives. If the window runs out with no pulse, the block switches the counter back to the internal tick by itself and raises a sticky status flag. It stays on the internal tick until software writes the source selection again. Set the prescaler so that the internal tick rate is close to the external pulse rate; the count then shows little jitter across a fallback. An external source that runs too fast is not detected and never causes a fallback.

Top module: `nt_counter_supervisor`

## Requirements
- R1: A one-cycle `srcWrite` stores `srcSel` as the source. Code 0 selects the internal tick, code 1 the macrotick input, code 2 the cycle-start input, and code 3 also selects the internal tick. `activeSrc` reports the source in use as 0, 1 or 2.
- R2: An internal tick occurs once every `prescaleCmp`+1 clock cycles. In internal mode the counter advances by exactly one per tick and holds otherwise.
- R3: In external mode, each rising edge on the selected input advances the counter by exactly one, no matter how long the input stays high. The non-selected input has no effect. The input is sampled through two flip-flops plus an edge register, so the counter changes on the third clock edge after the rising input is first sampled.
- R4: In external mode, a window counter counts internal ticks since the last selected pulse or the last `srcWrite`. When the `windowLen`-th tick arrives without a pulse, three things happen on that same edge: `fallbackFlag` goes to 1, `activeSrc` goes to 0, and the counter advances by one for that tick. A `windowLen` of 0 behaves like 1.
- R5: After a fallback, the counter advances only on internal ticks. Pulses on either external input are ignored, and the flag stays at 1, until the next `srcWrite`.
- R6: `srcWrite` clears `fallbackFlag` and restarts the window on the edge that samples it.
- R7: External pulses that arrive more often than the window length never cause a fallback.
- R8: The counter wraps from all ones to zero. `overflow` is high for exactly the one cycle in which the counter reads zero after the wrap.
- R9: After reset, the counter is 0, `overflow` is 0, `activeSrc` is 0 and `fallbackFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcSel | input | 2 | Source code, taken when `srcWrite` is high |
| srcWrite | input | 1 | One-cycle strobe that stores the source and clears the fallback flag |
| prescaleCmp | input | PRE_W | Internal tick period minus one, in clock cycles |
| windowLen | input | WIN_W | Supervision window length, in internal ticks |
| macroTickIn | input | 1 | Asynchronous network macrotick pulse |
| cycleStartIn | input | 1 | Asynchronous network cycle-start pulse |
| count | output | CNT_W | Free-running counter value |
| overflow | output | 1 | One-cycle pulse when the counter wraps to zero |
| activeSrc | output | 2 | Source currently advancing the counter |
| fallbackFlag | output | 1 | Sticky flag: the supervision window expired |

## Verification
The assertions check the following on every cycle. The counter holds whenever no increment strobe is present. `overflow` only ever appears with a zero count and lasts one cycle. Each detected edge lasts one cycle. A set fallback flag stays set until a write and forces the internal source. The flag can only rise while an external source is active, and a write always clears it.

Some things only the bench scenarios can show. These are the arithmetic of the tick rate against `prescaleCmp`, the exact count of external pulses, the number of ticks to fallback for each combination of window and prescaler, and the fact that the non-selected input and pulses after a fallback leave the count untouched.

// File: rtl/nt_pkg.sv
package nt_pkg;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_MTK = 2'd1,
    SRC_CYC = 2'd2
  } srcCode_e;

  typedef struct packed {
    logic inc;      // advance the free-running counter
    logic winClr;   // restart the supervision window
    logic winStep;  // one internal tick elapsed inside the window
  } ntStrobes_t;

endpackage

// File: rtl/nt_edge_sync.sv
module nt_edge_sync (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic risePulse
);

  logic meta;
  logic stable;
  logic stableDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta      <= 1'b0;
      stable    <= 1'b0;
      stableDly <= 1'b0;
    end else begin
      meta      <= asyncIn;
      stable    <= meta;
      stableDly <= stable;
    end
  end

  assign risePulse = stable & ~stableDly;

  // R3: a detected edge never lasts longer than one cycle
  assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    risePulse |=> !risePulse);

endmodule

// File: rtl/nt_supervisor_ctrl.sv
module nt_supervisor_ctrl
  import nt_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       srcSel,
  input  logic             srcWrite,
  input  logic [PRE_W-1:0] prescaleCmp,
  input  logic [1:0]       risePulse,
  input  logic             winHit,
  output ntStrobes_t       strobes,
  output logic [1:0]       activeSrc,
  output logic             fallbackFlag
);

  logic [PRE_W-1:0] prescCnt;
  logic             tick;
  srcCode_e         selReg;
  srcCode_e         selNext;
  logic             extSel;
  logic             extActive;
  logic             edgeSel;
  logic             failNow;

  // internal prescaler: one tick every prescaleCmp+1 cycles
  assign tick = (prescCnt >= prescaleCmp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prescCnt <= '0;
    else if (tick) prescCnt <= '0;
    else prescCnt <= prescCnt + 1'b1;
  end

  // decode the written code: anything that is not external means internal
  always_comb begin
    unique case (srcSel)
      2'd1:    selNext = SRC_MTK;
      2'd2:    selNext = SRC_CYC;
      default: selNext = SRC_INT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selReg <= SRC_INT;
    else if (srcWrite) selReg <= selNext;
  end

  assign extSel    = (selReg == SRC_MTK) || (selReg == SRC_CYC);
  assign extActive = extSel & ~fallbackFlag;
  assign edgeSel   = (selReg == SRC_MTK) ? risePulse[0] : risePulse[1];
  assign failNow   = extActive & tick & ~edgeSel & winHit & ~srcWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fallbackFlag <= 1'b0;
    else if (srcWrite) fallbackFlag <= 1'b0;
    else if (failNow) fallbackFlag <= 1'b1;
  end

  always_comb begin
    strobes.inc     = extActive ? (edgeSel | failNow) : tick;
    strobes.winClr  = srcWrite | ~extActive | edgeSel | failNow;
    strobes.winStep = ~strobes.winClr & tick;
  end

  assign activeSrc = extActive ? selReg : SRC_INT;

  // R5: the fallback flag holds until software writes the selection
  assert_fallback_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fallbackFlag && !srcWrite) |=> fallbackFlag);

  // R4: a fallen-back block reports the internal source
  assert_fallen_internal_R4: assert property (@(posedge clk) disable iff (!rstN)
    fallbackFlag |-> (activeSrc == SRC_INT));

  // R4: a fallback can only start while an external source was active
  assert_fallback_origin_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fallbackFlag) |-> $past(extActive));

  // R6: a write always leaves the flag clear
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    srcWrite |=> !fallbackFlag);

endmodule

// File: rtl/nt_count_path.sv
module nt_count_path
  import nt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ntStrobes_t       strobes,
  input  logic [WIN_W-1:0] windowLen,
  output logic             winHit,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [WIN_W-1:0] winCnt;
  logic [WIN_W:0]   winNext;

  assign winNext = {1'b0, winCnt} + 1'b1;
  assign winHit  = (winNext >= {1'b0, windowLen});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winCnt <= '0;
    else if (strobes.winClr) winCnt <= '0;
    else if (strobes.winStep) winCnt <= winNext[WIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= strobes.inc && (count == CNT_MAX);
      if (strobes.inc) count <= count + 1'b1;
    end
  end

  // R2: without an increment strobe the counter does not move
  assert_hold_no_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.inc |=> $stable(count));

  // R8: overflow is seen only together with a zero count
  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (count == '0));

  // R8: overflow lasts a single cycle
  assert_overflow_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> !overflow);

endmodule

// File: rtl/nt_counter_supervisor.sv
module nt_counter_supervisor
  import nt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       srcSel,
  input  logic             srcWrite,
  input  logic [PRE_W-1:0] prescaleCmp,
  input  logic [WIN_W-1:0] windowLen,
  input  logic             macroTickIn,
  input  logic             cycleStartIn,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic [1:0]       activeSrc,
  output logic             fallbackFlag
);

  localparam int NUM_EXT = 2;

  logic [NUM_EXT-1:0] extRaw;
  logic [NUM_EXT-1:0] risePulse;
  logic               winHit;
  ntStrobes_t         strobes;

  assign extRaw = {cycleStartIn, macroTickIn};

  for (genvar g = 0; g < NUM_EXT; g++) begin : gSync
    nt_edge_sync syncI (
      .clk       (clk),
      .rstN      (rstN),
      .asyncIn   (extRaw[g]),
      .risePulse (risePulse[g])
    );
  end

  nt_supervisor_ctrl #(.PRE_W(PRE_W)) ctrlI (
    .clk          (clk),
    .rstN         (rstN),
    .srcSel       (srcSel),
    .srcWrite     (srcWrite),
    .prescaleCmp  (prescaleCmp),
    .risePulse    (risePulse),
    .winHit       (winHit),
    .strobes      (strobes),
    .activeSrc    (activeSrc),
    .fallbackFlag (fallbackFlag)
  );

  nt_count_path #(.CNT_W(CNT_W), .WIN_W(WIN_W)) pathI (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .windowLen (windowLen),
    .winHit    (winHit),
    .count     (count),
    .overflow  (overflow)
  );

endmodule

// File: tb/nt_counter_supervisor_tb.sv
module nt_counter_supervisor_tb_top;

  localparam int CNT_W = 8;
  localparam int PRE_W = 4;
  localparam int WIN_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       srcSel = '0;
  logic             srcWrite = 1'b0;
  logic [PRE_W-1:0] prescaleCmp = '0;
  logic [WIN_W-1:0] windowLen = '0;
  logic             macroTickIn = 1'b0;
  logic             cycleStartIn = 1'b0;
  logic [CNT_W-1:0] count;
  logic             overflow;
  logic [1:0]       activeSrc;
  logic             fallbackFlag;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  nt_counter_supervisor #(.CNT_W(CNT_W), .PRE_W(PRE_W), .WIN_W(WIN_W)) dut_i (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .srcWrite(srcWrite),
    .prescaleCmp(prescaleCmp), .windowLen(windowLen),
    .macroTickIn(macroTickIn), .cycleStartIn(cycleStartIn),
    .count(count), .overflow(overflow), .activeSrc(activeSrc),
    .fallbackFlag(fallbackFlag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeSrc(input logic [1:0] code);
    @(negedge clk);
    srcSel = code;
    srcWrite = 1'b1;
    @(negedge clk);
    srcWrite = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one pulse on the chosen input (period 8, high 3); the other input toggles as noise
  task automatic pulseExt(input int which, input bit noise);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (which == 1) macroTickIn = (i < 3);
      else cycleStartIn = (i < 3);
      if (noise) begin
        if (which == 1) cycleStartIn = ~cycleStartIn;
        else macroTickIn = ~macroTickIn;
      end
    end
  endtask

  function automatic int delta(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return int'((a - b) & {CNT_W{1'b1}});
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] c0;
    int n;
    waitCycles(3);
    // R9 reset state
    check(count == 0, "R9 count", count, 0);
    check(overflow == 0, "R9 overflow", overflow, 0);
    check(activeSrc == 0, "R9 activeSrc", activeSrc, 0);
    check(fallbackFlag == 0, "R9 fallbackFlag", fallbackFlag, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: internal tick rate sweep over prescaler values
    writeSrc(2'd0);
    check(activeSrc == 0, "R1 internal code 0", activeSrc, 0);
    for (int p = 0; p < 6; p++) begin
      prescaleCmp = PRE_W'(p);
      waitCycles(20);
      c0 = count;
      waitCycles(7 * (p + 1));
      check(delta(count, c0) == 7, "R2 ticks per prescale", delta(count, c0), 7);
    end

    // R3: external pulse counting, both sources, non-selected input toggling
    prescaleCmp = 4'd1;
    windowLen = 4'd15;
    for (int s = 1; s <= 2; s++) begin
      writeSrc(2'(s));
      check(activeSrc == 2'(s), "R1 external code", activeSrc, s);
      for (int k = 1; k <= 6; k++) begin
        c0 = count;
        for (int j = 0; j < k; j++) pulseExt(s, 1'b1);
        macroTickIn = 1'b0;
        cycleStartIn = 1'b0;
        waitCycles(6);
        check(delta(count, c0) == k, "R3 edges counted", delta(count, c0), k);
        check(fallbackFlag == 0, "R7 no fallback while pulsing", fallbackFlag, 0);
      end
    end

    // R7: very fast pulses never trigger a fallback
    prescaleCmp = 4'd0;
    windowLen = 4'd6;
    writeSrc(2'd1);
    c0 = count;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      macroTickIn = (i % 2 == 0);
    end
    macroTickIn = 1'b0;
    waitCycles(6);
    check(delta(count, c0) == 30, "R7 fast edges counted", delta(count, c0), 30);
    check(fallbackFlag == 0, "R7 fast flag", fallbackFlag, 0);
    check(activeSrc == 1, "R7 fast source", activeSrc, 1);

    // R4: fallback timing sweep over window length and prescaler
    for (int w = 1; w <= 4; w++) begin
      for (int p = 0; p < 4; p++) begin
        prescaleCmp = PRE_W'(p);
        windowLen = WIN_W'(w);
        writeSrc(2'd1);
        check(fallbackFlag == 0, "R6 write clears flag", fallbackFlag, 0);
        c0 = count;
        n = 0;
        while (!fallbackFlag && n < 100) begin
          @(negedge clk);
          n++;
        end
        check(n >= (w - 1) * (p + 1) + 1 && n <= w * (p + 1), "R4 ticks to fallback",
              n, w * (p + 1));
        check(delta(count, c0) == 1, "R4 failing tick counted", delta(count, c0), 1);
        check(activeSrc == 0, "R4 source after fallback", activeSrc, 0);
      end
    end

    // R5: after fallback only ticks count; pulses ignored (prescaleCmp = 3)
    waitCycles(5);
    c0 = count;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      macroTickIn = (i % 2 == 0);
      cycleStartIn = (i % 3 == 0);
    end
    check(delta(count, c0) == 10, "R5 ticks only", delta(count, c0), 10);
    check(fallbackFlag == 1, "R5 flag sticky", fallbackFlag, 1);
    macroTickIn = 1'b0;
    cycleStartIn = 1'b0;

    // R6: rewrite clears and re-arms the external source
    windowLen = 4'd15;
    writeSrc(2'd2);
    check(fallbackFlag == 0, "R6 flag cleared", fallbackFlag, 0);
    check(activeSrc == 2, "R6 source restored", activeSrc, 2);

    // R1: code 3 selects the internal tick
    writeSrc(2'd3);
    check(activeSrc == 0, "R1 code 3 internal", activeSrc, 0);
    waitCycles(8);
    c0 = count;
    waitCycles(20);
    check(delta(count, c0) == 5, "R1 code 3 ticks", delta(count, c0), 5);

    // R8: wrap with one-cycle overflow
    prescaleCmp = 4'd0;
    waitCycles(4);
    n = 0;
    while (count != 8'hFF && n < 400) begin
      check(overflow == (count == 0), "R8 overflow only at zero", overflow, count == 0);
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    check(count == 0, "R8 wrap count", count, 0);
    check(overflow == 1, "R8 overflow pulse", overflow, 1);
    @(negedge clk);
    check(overflow == 0, "R8 overflow one cycle", overflow, 0);
    check(count == 1, "R8 count after wrap", count, 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule